// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Address Translation Buffer

This block caches virtual-to-physical page translations for a processor's memory port. The page size is 8 KiB, so the low 13 address bits are the page offset and pass through translation unchanged. The buffer is direct-mapped with 256 slots, and the slot is picked by virtual address bits [20:13]. Each slot holds one physical page base that all access classes share. Each slot also holds three independent tags with valid bits: one for instruction fetch, one for data load and one for data store. As a result, a page that has been refilled for loads still misses for stores or fetches until the walker refills it for that class as well.

A lookup presents a virtual address and two class flags, and the registered result appears one cycle later. The result is either a hit with the physical address, or a miss with a refill request that carries the virtual address and the class. An external page-table walker answers through the refill port. The refill writes the page base into the slot and sets the tag of the one requesting class. A write to the page-table base register stores the base with its offset bits cleared and invalidates every tag in all three classes.

Top module: `tlbx_split`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rs_valid`, `rs_hit` and `miss_req` are low and `ptb_q` is zero; no lookup hits until a refill has been made.
- R2: The class of a lookup is fetch when `lk_fetch` is high, otherwise store when `lk_store` is high, otherwise load; class codes are 0 load, 1 store, 2 fetch on both `miss_class` and `rf_class`.
- R3: The slot is virtual address bits [20:13]; a hit needs the selected class's tag at that slot to be valid and to equal virtual address bits [31:21] exactly, so two pages that differ only above bit 20 never hit for each other.
- R4: Every lookup with `lk_valid` high yields, one clock edge later, `rs_valid` high and exactly one of `rs_hit` and `miss_req`; with `lk_valid` low, `rs_valid`, `rs_hit` and `miss_req` are low on the following cycle.
- R5: On a hit, `rs_paddr` is the stored page base (bits [31:13]) concatenated with the lookup's bits [12:0].
- R6: On a miss, `miss_req` is high with `miss_vaddr` equal to the looked-up address and `miss_class` equal to its class code.
- R7: A refill applies to lookups presented from the next cycle on; a lookup in the same cycle as the refill sees the old contents.
- R8: A refill for one class leaves the valid state and tags of the other two classes at that slot, and every other slot, unchanged.
- R9: The page base is shared: a refill for any class replaces the base that hits of every class at that slot return.
- R10: A page-table base write makes `ptb_q` equal to `ptb_wdata` with bits [12:0] cleared, from the next cycle.
- R11: A page-table base write invalidates every tag of all three classes; a refill in the same cycle does not survive it.
- R12: A refill with `rf_class` equal to 3 changes neither any tag nor any page base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_store | input | 1 | Lookup is a data store |
| rs_valid | output | 1 | Registered lookup result present |
| rs_hit | output | 1 | Lookup hit |
| rs_paddr | output | 32 | Physical address on a hit, zero otherwise |
| miss_req | output | 1 | Lookup missed, refill requested |
| miss_vaddr | output | 32 | Virtual address of the lookup |
| miss_class | output | 2 | Class code of the lookup |
| rf_valid | input | 1 | Refill write |
| rf_vaddr | input | 32 | Virtual address being refilled |
| rf_class | input | 2 | Class whose tag is set |
| rf_pbase | input | 32 | Physical page base; bits [12:0] are ignored |
| ptb_we | input | 1 | Page-table base write, flushes all tags |
| ptb_wdata | input | 32 | Page-table base write data |
| ptb_q | output | 32 | Aligned page-table base |

## Verification
Lookup results, refill requests and `ptb_q` are all due one clock edge after the inputs that cause them. A refill or flush changes only lookups presented in a later cycle. The bench drives every input at the falling edge. At the rising edge it captures the expected result from its model as the model stood before that edge's updates, and only then applies refills and flushes to the model. It compares the outputs at the next falling edge. Same-cycle collisions are placed as directed cases: a refill with a lookup, and a flush with a refill. The random phase then mixes these collisions freely.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

   typedef enum logic [1:0] {
      CLS_LOAD  = 2'd0,
      CLS_STORE = 2'd1,
      CLS_FETCH = 2'd2
   } acc_cls_e;

   localparam int unsigned NUM_CLS = 3;

   function automatic acc_cls_e pick_class(input logic is_fetch, input logic is_store);
      if (is_fetch)      return CLS_FETCH;
      else if (is_store) return CLS_STORE;
      else               return CLS_LOAD;
   endfunction

endpackage

// File: rtl/tlbx_class_sel.sv
module tlbx_class_sel
   import tlbx_pkg::*;
(
   input  logic     is_fetch,
   input  logic     is_store,
   output acc_cls_e cls
);

   always_comb begin
      cls = pick_class(is_fetch, is_store);
   end

endmodule

// File: rtl/tlbx_tag_bank.sv
module tlbx_tag_bank #(
   parameter int unsigned ENTRIES = 256,
   parameter int unsigned TAG_W   = 11,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit
);

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   always_comb begin
      rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   end

   // R11: a flush leaves no valid tag behind
   a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   // R11: a refill colliding with a flush is lost
   a_r11_flush_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && wr_en) |=> !valid_q[$past(wr_idx)]);

   // R8: without a write to this class, its valid state is stable
   a_r8_idle_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !flush) |=> $stable(valid_q));

endmodule

// File: rtl/tlbx_base_ram.sv
module tlbx_base_ram #(
   parameter int unsigned ENTRIES = 256,
   parameter int unsigned BASE_W  = 19,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BASE_W-1:0] rd_base
);

   logic [BASE_W-1:0] base_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         base_q[wr_idx] <= wr_base;
      end
   end

   always_comb begin
      rd_base = base_q[rd_idx];
   end

   // R9: the shared slot holds the last written base
   a_r9_base_written: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)));

endmodule

// File: rtl/tlbx_split.sv
module tlbx_split
   import tlbx_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned PAGE_SHIFT = 13,
   parameter int unsigned ENTRIES    = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_vaddr,
   input  logic              lk_fetch,
   input  logic              lk_store,
   output logic              rs_valid,
   output logic              rs_hit,
   output logic [PA_W-1:0]   rs_paddr,
   output logic              miss_req,
   output logic [ADDR_W-1:0] miss_vaddr,
   output logic [1:0]        miss_class,
   input  logic              rf_valid,
   input  logic [ADDR_W-1:0] rf_vaddr,
   input  logic [1:0]        rf_class,
   input  logic [PA_W-1:0]   rf_pbase,
   input  logic              ptb_we,
   input  logic [PA_W-1:0]   ptb_wdata,
   output logic [PA_W-1:0]   ptb_q
);

   localparam int unsigned IDX_W  = $clog2(ENTRIES);
   localparam int unsigned TAG_LO = PAGE_SHIFT + IDX_W;
   localparam int unsigned TAG_W  = ADDR_W - TAG_LO;
   localparam int unsigned BASE_W = PA_W - PAGE_SHIFT;

   generate
      if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (TAG_LO >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W must exceed PAGE_SHIFT plus the index width");
      end
      if (PAGE_SHIFT >= PA_W) begin : g_bad_pa
         $error("PA_W must exceed PAGE_SHIFT");
      end
   endgenerate

   // lookup side
   acc_cls_e                lk_cls;
   logic [IDX_W-1:0]        lk_idx;
   logic [TAG_W-1:0]        lk_tag;
   logic [PAGE_SHIFT-1:0]   lk_off;
   logic [NUM_CLS-1:0]      hit_vec;
   logic                    hit_sel;
   logic [BASE_W-1:0]       rd_base;

   // refill side
   logic [IDX_W-1:0]        rf_idx;
   logic [TAG_W-1:0]        rf_tag;
   logic                    rf_legal;

   logic                    unused_low_bits;

   assign lk_idx   = lk_vaddr[PAGE_SHIFT +: IDX_W];
   assign lk_tag   = lk_vaddr[ADDR_W-1:TAG_LO];
   assign lk_off   = lk_vaddr[PAGE_SHIFT-1:0];
   assign rf_idx   = rf_vaddr[PAGE_SHIFT +: IDX_W];
   assign rf_tag   = rf_vaddr[ADDR_W-1:TAG_LO];
   assign rf_legal = rf_valid && (rf_class != 2'd3);
   assign unused_low_bits = ^{rf_vaddr[PAGE_SHIFT-1:0], rf_pbase[PAGE_SHIFT-1:0],
                              ptb_wdata[PAGE_SHIFT-1:0]};

   tlbx_class_sel u_cls (
      .is_fetch (lk_fetch),
      .is_store (lk_store),
      .cls      (lk_cls)
   );

   generate
      for (genvar c = 0; c < NUM_CLS; c++) begin : g_bank
         logic bank_wr;
         assign bank_wr = rf_valid && (rf_class == c[1:0]);
         tlbx_tag_bank #(
            .ENTRIES (ENTRIES),
            .TAG_W   (TAG_W)
         ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (ptb_we),
            .wr_en  (bank_wr),
            .wr_idx (rf_idx),
            .wr_tag (rf_tag),
            .rd_idx (lk_idx),
            .rd_tag (lk_tag),
            .rd_hit (hit_vec[c])
         );
      end
   endgenerate

   tlbx_base_ram #(
      .ENTRIES (ENTRIES),
      .BASE_W  (BASE_W)
   ) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rf_legal),
      .wr_idx  (rf_idx),
      .wr_base (rf_pbase[PA_W-1:PAGE_SHIFT]),
      .rd_idx  (lk_idx),
      .rd_base (rd_base)
   );

   always_comb begin
      unique case (lk_cls)
         CLS_FETCH: hit_sel = hit_vec[2];
         CLS_STORE: hit_sel = hit_vec[1];
         default:   hit_sel = hit_vec[0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid   <= 1'b0;
         rs_hit     <= 1'b0;
         rs_paddr   <= '0;
         miss_req   <= 1'b0;
         miss_vaddr <= '0;
         miss_class <= 2'd0;
      end else begin
         rs_valid   <= lk_valid;
         rs_hit     <= lk_valid && hit_sel;
         rs_paddr   <= (lk_valid && hit_sel) ? {rd_base, lk_off} : '0;
         miss_req   <= lk_valid && !hit_sel;
         miss_vaddr <= lk_vaddr;
         miss_class <= lk_cls;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptb_q <= '0;
      end else if (ptb_we) begin
         ptb_q <= {ptb_wdata[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      end
   end

   // R4: no result without a lookup the cycle before
   a_r4_quiet_without_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(lk_valid) |-> (!rs_valid && !rs_hit && !miss_req));

   // R4: hit and miss never together
   a_r4_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rs_hit && miss_req));

   // R2: fetch flag dominates the class
   a_r2_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && $past(lk_fetch)) |-> (miss_class == 2'd2));

   // R6: miss reports the looked-up address
   a_r6_miss_addr: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req |-> (miss_vaddr == $past(lk_vaddr)));

   // R5: the page offset passes through
   a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rs_hit |-> (rs_paddr[PAGE_SHIFT-1:0] == $past(lk_vaddr[PAGE_SHIFT-1:0])));

   // R10: base register is aligned copy of written value
   a_r10_ptb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ptb_we) |-> (ptb_q == {$past(ptb_wdata[PA_W-1:PAGE_SHIFT]), {PAGE_SHIFT{1'b0}}}));

endmodule

// File: tb/sim_tlbx_split.sv
`timescale 1ns/1ps
module sim_tlbx_split;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_fetch = 1'b0;
   logic        lk_store = 1'b0;
   logic        rs_valid, rs_hit, miss_req;
   logic [31:0] rs_paddr, miss_vaddr, ptb_q;
   logic [1:0]  miss_class;
   logic        rf_valid = 1'b0;
   logic [31:0] rf_vaddr = '0;
   logic [1:0]  rf_class = 2'd0;
   logic [31:0] rf_pbase = '0;
   logic        ptb_we = 1'b0;
   logic [31:0] ptb_wdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   // reference model: full page number tags, valid bits, shared base
   logic [18:0] m_tag  [3][256];
   logic        m_v    [3][256];
   logic [18:0] m_base [256];
   logic [31:0] m_ptb;

   always #4 clk = ~clk;

   tlbx_split u0 (
      .clk, .rst_n, .lk_valid, .lk_vaddr, .lk_fetch, .lk_store,
      .rs_valid, .rs_hit, .rs_paddr, .miss_req, .miss_vaddr, .miss_class,
      .rf_valid, .rf_vaddr, .rf_class, .rf_pbase, .ptb_we, .ptb_wdata, .ptb_q
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int cls_of(input logic f, input logic s);
      return f ? 2 : (s ? 1 : 0);
   endfunction

   task automatic model_flush();
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < 256; i++) m_v[c][i] = 1'b0;
   endtask

   task automatic set_in(input logic lv, input logic [31:0] va, input logic f, input logic s,
                         input logic rv, input logic [31:0] rva, input logic [1:0] rc,
                         input logic [31:0] rb, input logic pw, input logic [31:0] pd);
      lk_valid = lv; lk_vaddr = va; lk_fetch = f; lk_store = s;
      rf_valid = rv; rf_vaddr = rva; rf_class = rc; rf_pbase = rb;
      ptb_we = pw; ptb_wdata = pd;
   endtask

   // one clock: expected from model before the edge, model updated, outputs checked
   task automatic step(input string req);
      logic e_hit, e_miss;
      logic [31:0] e_pa;
      int c, ix;
      @(posedge clk);
      c  = cls_of(lk_fetch, lk_store);
      ix = int'(lk_vaddr[20:13]);
      e_hit  = lk_valid && m_v[c][ix] && (m_tag[c][ix] == lk_vaddr[31:13]);
      e_miss = lk_valid && !e_hit;
      e_pa   = {m_base[ix], lk_vaddr[12:0]};
      if (rf_valid && rf_class != 2'd3) begin
         m_base[int'(rf_vaddr[20:13])] = rf_pbase[31:13];
         m_tag[int'(rf_class)][int'(rf_vaddr[20:13])] = rf_vaddr[31:13];
         m_v[int'(rf_class)][int'(rf_vaddr[20:13])] = 1'b1;
      end
      if (ptb_we) begin
         model_flush();
         m_ptb = {ptb_wdata[31:13], 13'd0};
      end
      @(negedge clk);
      chk(rs_valid == lk_valid, req, "rs_valid", 32'(rs_valid), 32'(lk_valid));
      chk(rs_hit == e_hit, req, "rs_hit", 32'(rs_hit), 32'(e_hit));
      chk(miss_req == e_miss, req, "miss_req", 32'(miss_req), 32'(e_miss));
      if (e_hit) chk(rs_paddr == e_pa, req, "rs_paddr", rs_paddr, e_pa);
      if (e_miss) begin
         chk(miss_vaddr == lk_vaddr, req, "miss_vaddr", miss_vaddr, lk_vaddr);
         chk(miss_class == 2'(c), req, "miss_class", 32'(miss_class), 32'(c));
      end
      chk(ptb_q == m_ptb, req, "ptb_q", ptb_q, m_ptb);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] pa, pb;
      void'($urandom(32'd2024));
      model_flush();
      m_ptb = '0;
      for (int i = 0; i < 256; i++) m_base[i] = '0;
      pa = 32'h0020_6123;             // slot 0x03
      pb = pa ^ 32'h0200_0000;        // same slot, differs above bit 20
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!rs_valid && !rs_hit && !miss_req, "R1", "outputs in reset",
          {rs_valid, rs_hit, miss_req}, 32'd0);
      chk(ptb_q == 32'd0, "R1", "ptb_q in reset", ptb_q, 32'd0);
      rst_n = 1'b1;
      // R1/R6: first lookup misses
      set_in(1, pa, 0, 0, 0, 0, 0, 0, 0, 0); step("R1");
      // R7: refill with a same-cycle lookup still misses
      set_in(1, pa, 0, 0, 1, pa, 2'd0, 32'h1234_5FFF, 0, 0); step("R7");
      // R7/R5: next cycle hits
      set_in(1, pa, 0, 0, 0, 0, 0, 0, 0, 0); step("R5");
      // R8: store and fetch classes still miss
      set_in(1, pa, 0, 1, 0, 0, 0, 0, 0, 0); step("R8");
      // R2: fetch wins over store
      set_in(1, pa, 1, 1, 0, 0, 0, 0, 0, 0); step("R2");
      chk(miss_class == 2'd2, "R2", "fetch priority", 32'(miss_class), 32'd2);
      // R9: store refill replaces shared base
      set_in(0, 0, 0, 0, 1, pa, 2'd1, 32'hABCD_E000, 0, 0); step("R9");
      set_in(1, pa, 0, 0, 0, 0, 0, 0, 0, 0); step("R9");
      chk(rs_paddr == {19'(32'hABCD_E000 >> 13), 13'h0123}, "R9", "load sees new base",
          rs_paddr, {19'(32'hABCD_E000 >> 13), 13'h0123});
      // R3: alias in same slot misses
      set_in(1, pb, 0, 0, 0, 0, 0, 0, 0, 0); step("R3");
      // R12: class code 3 is ignored
      set_in(0, 0, 0, 0, 1, pb, 2'd3, 32'h7777_7000, 0, 0); step("R12");
      set_in(1, pa, 0, 1, 0, 0, 0, 0, 0, 0); step("R12");
      set_in(1, pb, 0, 0, 0, 0, 0, 0, 0, 0); step("R12");
      // R11/R10: flush with colliding refill
      set_in(0, 0, 0, 0, 1, pa, 2'd2, 32'h5555_5000, 1, 32'hDEAD_BEEF); step("R10");
      chk(ptb_q == 32'hDEAD_A000, "R10", "aligned base", ptb_q, 32'hDEAD_A000);
      set_in(1, pa, 1, 0, 0, 0, 0, 0, 0, 0); step("R11");
      set_in(1, pa, 0, 0, 0, 0, 0, 0, 0, 0); step("R11");
      // R4: no lookup, no result
      set_in(0, pa, 0, 0, 0, 0, 0, 0, 0, 0); step("R4");
      // random mix over a small page pool
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] va, rva;
         int r;
         va  = {($urandom % 2) ? 11'h001 : 11'h402, 8'($urandom % 4), 13'($urandom)};
         rva = {($urandom % 2) ? 11'h001 : 11'h402, 8'($urandom % 4), 13'($urandom)};
         r = int'($urandom % 100);
         set_in(r < 70, va, ($urandom % 3) == 0, ($urandom % 2) == 0,
                ($urandom % 4) == 0, rva, 2'($urandom), $urandom,
                r == 99, $urandom);
         step("R3");
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule